// File: doc/BRIEF.md
# Trace Unit Programming and Lock Front End

This block is the register front end of a program-flow trace unit. A bus master reaches it through a simple APB-style slave port. Every transfer completes in its access phase with no wait states. Configuration registers are guarded by a software lock. After reset the block is locked. A write of the unlock key to the key register opens the other registers, and any other value written there closes them again.

The control register holds a power-down vote and a programming-mode request. The trace pipeline, which is outside this block, reports through a drain-idle input when it has emptied. A status bit then acknowledges entry to programming mode. That bit, also driven on an output for the pipeline, falls one clock after the request is withdrawn. Software sets the request and polls the status bit with a timeout.

Read-only capability words describe the unit's resources. A clock-enable output ORs three permanent register-level votes with two temporary sources: reset requests and an ongoing bus access.

Top module: `trc_progif`

## Requirements
- R1: After reset the control register (byte offset 0x000) reads 0x00001000, the sync-period register (0x010) reads 0x00000080, the power-up register (0x014) reads 0, the status register (0x00C) reads 0, and the lock status register (0x01C) reads 1 in bit 0.
- R2: A write of the unlock key (default 0xA5C30F1E) to the key register (0x018) clears lock status bit 0. A write of any other value to the key register sets it.
- R3: While locked, writes to the control, sync-period and power-up registers leave their read-back values unchanged.
- R4: While unlocked, the control and sync-period registers read back the full 32-bit value written. Bit 0 of the power-up register reads back as written. Control bit 0 is the power-down vote and control bit 10 is the programming-mode request.
- R5: Status bit 1 (and output `trc_prog_o`) becomes 1 only when control bit 10 is 1 and `drain_idle` has been sampled high on IDLE_CYCLES (default 2) consecutive clock edges. With the request already set, the status bit rises on the edge that follows the last of those idle edges. Once set, it stays 1 while bit 10 stays 1.
- R6: When control bit 10 is cleared, status bit 1 falls on the next clock edge.
- R7: `clk_en` is 1 when any of these holds: `ext_clk_vote` is 1, control bit 0 is 0, power-up bit 0 is 1, `core_rst_req` is 1, `dbg_rst_req` is 1, or `psel` is 1. Otherwise it is 0.
- R8: The capability register (0x004) reports comparator pairs in bits [3:0], counters in [15:13], external inputs in [19:17], external outputs in [22:20] and context comparators in [25:24]. With the defaults (4, 2, 4, 2, 1) it reads 0x01284004.
- R9: The system register (0x008) reports FIFO-full support in bit 8 and the processor count in bits [14:12]. With the defaults it reads 0x00001100.
- R10: Unmapped addresses read 0. Writes to the capability, system and status registers have no effect on what they read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| drain_idle | input | 1 | Trace pipeline drained and idle |
| ext_clk_vote | input | 1 | External permanent clock vote |
| core_rst_req | input | 1 | Core reset asserted |
| dbg_rst_req | input | 1 | Debug reset asserted |
| trc_prog_o | output | 1 | Programming mode acknowledged |
| clk_en | output | 1 | Trace unit clock enable |

## Verification
The checker assumes bus transfers follow the two-phase protocol. Each transfer has a setup cycle with `penable` low, then one access cycle, with address and data held across both. The checker also assumes `drain_idle` is a synchronous level that may toggle on any cycle. The bench drives every transfer through one write task and one read task that follow this order, and changes inputs only on falling clock edges. The handshake tests hold the request steady while `drain_idle` is pulsed for a single cycle and then held for a longer run, so both the broken-run and the full-run cases of the idle count are exercised.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_CAPS   = 12'h004;
  localparam logic [11:0] OFS_SYSCAP = 12'h008;
  localparam logic [11:0] OFS_STAT   = 12'h00C;
  localparam logic [11:0] OFS_SYNC   = 12'h010;
  localparam logic [11:0] OFS_PWRUP  = 12'h014;
  localparam logic [11:0] OFS_KEY    = 12'h018;
  localparam logic [11:0] OFS_LOCKST = 12'h01C;

  localparam int CTRL_PDOWN_BIT = 0;
  localparam int CTRL_PROG_BIT  = 10;
  localparam int STAT_PROG_BIT  = 1;

  localparam logic [31:0] CTRL_RST = 32'h0000_1000;
  localparam logic [31:0] SYNC_RST = 32'h0000_0080;

  typedef enum logic {LK_OPEN = 1'b0, LK_SHUT = 1'b1} lock_e;
endpackage

// File: rtl/trc_lock.sv
module trc_lock #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              locked_o
);
  import trc_pkg::*;

  lock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr) st_d = (key_data == DATA_W'(KEY)) ? LK_OPEN : LK_SHUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_SHUT;
    else        st_q <= st_d;
  end

  assign locked_o = (st_q == LK_SHUT);
endmodule

// File: rtl/trc_prog_hs.sv
module trc_prog_hs #(
  parameter int IDLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_req,
  input  logic drain_idle,
  output logic ack_o
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] run_q, run_d;
  logic             ack_q, ack_d;

  // consecutive idle edges, saturating at the required length
  always_comb begin
    if (!drain_idle)          run_d = '0;
    else if (run_q == RUN_MAX) run_d = run_q;
    else                      run_d = run_q + CNT_W'(1);
    ack_d = prog_req & (ack_q | (run_q == RUN_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      ack_q <= 1'b0;
    end else begin
      run_q <= run_d;
      ack_q <= ack_d;
    end
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/trc_clk_vote.sv
module trc_clk_vote #(
  parameter int N_PERM = 3,
  parameter int N_TEMP = 3
) (
  input  logic [N_PERM-1:0] perm_votes,
  input  logic [N_TEMP-1:0] temp_votes,
  output logic              clk_en_o
);
  assign clk_en_o = (|perm_votes) | (|temp_votes);
endmodule

// File: rtl/trc_progif.sv
module trc_progif #(
  parameter int          ADDR_W      = 12,
  parameter logic [31:0] UNLOCK_KEY  = 32'hA5C3_0F1E,
  parameter int          IDLE_CYCLES = 2,
  parameter int          ACMP_PAIRS  = 4,
  parameter int          CNTRS       = 2,
  parameter int          EXT_IN      = 4,
  parameter int          EXT_OUT     = 2,
  parameter int          CID_CMPS    = 1,
  parameter int          FIFOFULL_EN = 1,
  parameter int          PROCS       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              drain_idle,
  input  logic              ext_clk_vote,
  input  logic              core_rst_req,
  input  logic              dbg_rst_req,
  output logic              trc_prog_o,
  output logic              clk_en
);
  import trc_pkg::*;

  localparam int DATA_W = 32;

  logic              wr_acc, cfg_wr_ok, locked;
  logic [DATA_W-1:0] ctrl_q, ctrl_d, sync_q, sync_d;
  logic              pwrup_q, pwrup_d, prog_ack;
  logic [DATA_W-1:0] caps_word, sys_word;

  assign wr_acc    = psel & penable & pwrite;
  assign cfg_wr_ok = wr_acc & ~locked;

  trc_lock #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (wr_acc && (paddr == ADDR_W'(OFS_KEY))),
    .key_data (pwdata),
    .locked_o (locked)
  );

  // next-state for configuration registers
  always_comb begin
    ctrl_d  = ctrl_q;
    sync_d  = sync_q;
    pwrup_d = pwrup_q;
    if (cfg_wr_ok) begin
      if (paddr == ADDR_W'(OFS_CTRL))  ctrl_d  = pwdata;
      if (paddr == ADDR_W'(OFS_SYNC))  sync_d  = pwdata;
      if (paddr == ADDR_W'(OFS_PWRUP)) pwrup_d = pwdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      sync_q  <= SYNC_RST;
      pwrup_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      sync_q  <= sync_d;
      pwrup_q <= pwrup_d;
    end
  end

  trc_prog_hs #(.IDLE_CYCLES(IDLE_CYCLES)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_req   (ctrl_q[CTRL_PROG_BIT]),
    .drain_idle (drain_idle),
    .ack_o      (prog_ack)
  );

  trc_clk_vote #(.N_PERM(3), .N_TEMP(3)) u_vote (
    .perm_votes ({ext_clk_vote, ~ctrl_q[CTRL_PDOWN_BIT], pwrup_q}),
    .temp_votes ({core_rst_req, dbg_rst_req, psel}),
    .clk_en_o   (clk_en)
  );

  // capability words built from parameters
  always_comb begin
    caps_word          = '0;
    caps_word[3:0]     = 4'(ACMP_PAIRS);
    caps_word[15:13]   = 3'(CNTRS);
    caps_word[19:17]   = 3'(EXT_IN);
    caps_word[22:20]   = 3'(EXT_OUT);
    caps_word[25:24]   = 2'(CID_CMPS);
    sys_word           = '0;
    sys_word[8]        = (FIFOFULL_EN != 0);
    sys_word[14:12]    = 3'(PROCS);
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      ADDR_W'(OFS_CTRL):   prdata = ctrl_q;
      ADDR_W'(OFS_CAPS):   prdata = caps_word;
      ADDR_W'(OFS_SYSCAP): prdata = sys_word;
      ADDR_W'(OFS_STAT):   prdata[STAT_PROG_BIT] = prog_ack;
      ADDR_W'(OFS_SYNC):   prdata = sync_q;
      ADDR_W'(OFS_PWRUP):  prdata[0] = pwrup_q;
      ADDR_W'(OFS_LOCKST): prdata[0] = locked;
      default:             prdata = '0;
    endcase
  end

  assign trc_prog_o = prog_ack;
endmodule

// File: rtl/trc_progif_chk.sv
module trc_progif_chk #(
  parameter int          ADDR_W = 12,
  parameter logic [31:0] KEY    = 32'hA5C3_0F1E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       ctrl_q,
  input logic              locked,
  input logic              prog_ack,
  input logic              drain_idle,
  input logic              core_rst_req,
  input logic              dbg_rst_req,
  input logic              clk_en
);
  import trc_pkg::*;

  logic wr;
  assign wr = psel & penable & pwrite;

  a_r3_locked_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && paddr == ADDR_W'(OFS_CTRL)) |=> $stable(ctrl_q));

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'(OFS_KEY) && pwdata == KEY) |=> !locked);

  a_r2_other_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'(OFS_KEY) && pwdata != KEY) |=> locked);

  a_r5_ack_after_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ack) |-> ($past(ctrl_q[CTRL_PROG_BIT]) && $past(drain_idle, 2)));

  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTRL_PROG_BIT] |=> !prog_ack);

  a_r7_temp_votes: assert property (@(posedge clk) disable iff (!rst_n)
    (psel || core_rst_req || dbg_rst_req) |-> clk_en);
endmodule

bind trc_progif trc_progif_chk #(.ADDR_W(ADDR_W), .KEY(UNLOCK_KEY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .psel         (psel),
  .penable      (penable),
  .pwrite       (pwrite),
  .paddr        (paddr),
  .pwdata       (pwdata),
  .ctrl_q       (ctrl_q),
  .locked       (locked),
  .prog_ack     (prog_ack),
  .drain_idle   (drain_idle),
  .core_rst_req (core_rst_req),
  .dbg_rst_req  (dbg_rst_req),
  .clk_en       (clk_en)
);

// File: tb/trc_progif_test.sv
module trc_progif_test;
  localparam int          AW  = 12;
  localparam logic [31:0] KEY = 32'hA5C3_0F1E;

  logic clk, rst_n, psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0] pwdata, prdata;
  logic drain_idle, ext_clk_vote, core_rst_req, dbg_rst_req;
  logic trc_prog_o, clk_en;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] rd;

  trc_progif uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .drain_idle(drain_idle),
    .ext_clk_vote(ext_clk_vote), .core_rst_req(core_rst_req),
    .dbg_rst_req(dbg_rst_req), .trc_prog_o(trc_prog_o), .clk_en(clk_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {pdown, pwrup, ext, core_rst, dbg_rst, expected clk_en}
  localparam logic [5:0] CLKV [8] = '{
    6'b10000_0, 6'b00000_1, 6'b11000_1, 6'b10100_1,
    6'b10010_1, 6'b10001_1, 6'b01111_1, 6'b10000_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    drain_idle = 1'b0; ext_clk_vote = 1'b0; core_rst_req = 1'b0; dbg_rst_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(12'h000, rd); chk("R1 ctrl", rd, 32'h0000_1000);
    bus_rd(12'h010, rd); chk("R1 sync", rd, 32'h0000_0080);
    bus_rd(12'h014, rd); chk("R1 pwrup", rd, 32'h0);
    bus_rd(12'h00C, rd); chk("R1 stat", rd, 32'h0);
    bus_rd(12'h01C, rd); chk("R1 lockst", rd, 32'h1);
    chk("R1 prog out", {31'b0, trc_prog_o}, 32'h0);

    // R8 R9 capability words
    bus_rd(12'h004, rd); chk("R8 caps", rd, 32'h0128_4004);
    bus_rd(12'h008, rd); chk("R9 syscap", rd, 32'h0000_1100);

    // R3 writes ignored while locked
    bus_wr(12'h000, 32'h0000_0401);
    bus_rd(12'h000, rd); chk("R3 ctrl locked", rd, 32'h0000_1000);
    bus_wr(12'h010, 32'h0000_1234);
    bus_rd(12'h010, rd); chk("R3 sync locked", rd, 32'h0000_0080);
    bus_wr(12'h014, 32'h1);
    bus_rd(12'h014, rd); chk("R3 pwrup locked", rd, 32'h0);
    chk("R3 no prog", {31'b0, trc_prog_o}, 32'h0);

    // R2 unlock
    bus_wr(12'h018, 32'h1234_5678);
    bus_rd(12'h01C, rd); chk("R2 wrong key stays locked", rd, 32'h1);
    bus_wr(12'h018, KEY);
    bus_rd(12'h01C, rd); chk("R2 key unlocks", rd, 32'h0);

    // R4 read-back
    bus_wr(12'h000, 32'hF00D_1001);
    bus_rd(12'h000, rd); chk("R4 ctrl", rd, 32'hF00D_1001);
    bus_wr(12'h010, 32'h0000_ABCD);
    bus_rd(12'h010, rd); chk("R4 sync", rd, 32'h0000_ABCD);
    bus_wr(12'h014, 32'hFFFF_FFFF);
    bus_rd(12'h014, rd); chk("R4 pwrup", rd, 32'h1);
    bus_wr(12'h014, 32'h0);

    // R10 read-only and unmapped
    bus_wr(12'h004, 32'h0);
    bus_rd(12'h004, rd); chk("R10 caps ro", rd, 32'h0128_4004);
    bus_wr(12'h008, 32'h0);
    bus_rd(12'h008, rd); chk("R10 syscap ro", rd, 32'h0000_1100);
    bus_wr(12'h00C, 32'hFFFF_FFFF);
    bus_rd(12'h00C, rd); chk("R10 stat ro", rd, 32'h0);
    bus_wr(12'h0F0, 32'hFFFF_FFFF);
    bus_rd(12'h0F0, rd); chk("R10 unmapped", rd, 32'h0);

    // R7 clock enable vector table
    for (int i = 0; i < 8; i++) begin
      bus_wr(12'h000, {31'b0, CLKV[i][5]});
      bus_wr(12'h014, {31'b0, CLKV[i][4]});
      @(negedge clk);
      ext_clk_vote = CLKV[i][3]; core_rst_req = CLKV[i][2]; dbg_rst_req = CLKV[i][1];
      #1 chk($sformatf("R7 vec%0d", i), {31'b0, clk_en}, {31'b0, CLKV[i][0]});
    end
    ext_clk_vote = 1'b0; core_rst_req = 1'b0; dbg_rst_req = 1'b0;
    // R7 bus access as temporary vote (power-down still set)
    @(negedge clk);
    chk("R7 idle off", {31'b0, clk_en}, 32'h0);
    psel = 1'b1; paddr = 12'h0F0;
    #1 chk("R7 psel on", {31'b0, clk_en}, 32'h1);
    @(negedge clk); psel = 1'b0;

    // R5 handshake: request with pipeline busy
    bus_wr(12'h000, 32'h0000_0400);
    repeat (4) @(negedge clk);
    chk("R5 busy no ack", {31'b0, trc_prog_o}, 32'h0);
    drain_idle = 1'b1;
    @(negedge clk); drain_idle = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 short idle no ack", {31'b0, trc_prog_o}, 32'h0);
    drain_idle = 1'b1;
    @(negedge clk); chk("R5 idle edge1", {31'b0, trc_prog_o}, 32'h0);
    @(negedge clk); chk("R5 idle edge2", {31'b0, trc_prog_o}, 32'h0);
    @(negedge clk); chk("R5 ack rises", {31'b0, trc_prog_o}, 32'h1);
    drain_idle = 1'b0;
    bus_rd(12'h00C, rd); chk("R5 stat bit1", rd, 32'h2);
    chk("R5 ack held", {31'b0, trc_prog_o}, 32'h1);

    // R6 clear request
    bus_wr(12'h000, 32'h0);
    chk("R6 ack before drop", {31'b0, trc_prog_o}, 32'h1);
    @(negedge clk);
    chk("R6 ack dropped", {31'b0, trc_prog_o}, 32'h0);

    // R2 relock then R3
    bus_wr(12'h018, 32'h0);
    bus_rd(12'h01C, rd); chk("R2 zero relocks", rd, 32'h1);
    bus_wr(12'h000, 32'h0000_0401);
    bus_rd(12'h000, rd); chk("R3 ctrl after relock", rd, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule